// File: doc/BRIEF.md
# I2C Slave Protocol Error Classifier

This block sits behind the bit-level receiver of an I2C slave that serves a register and memory access port. It does not touch SDA or SCL itself. It sees the bus as a stream of decoded events: START, STOP, and each received byte together with the level of its ninth (acknowledge) bit. From that stream it runs the slave transaction sequence. The sequence is a device address byte, three memory-address bytes that form a word address, and then data bytes that are packed into 32-bit words.

When a START or STOP or a missing acknowledge breaks that sequence, the block names the fault with an error code under the I2C group number. It hands the record to an error log, provided reporting is enabled. It also decides what survives the fault. A partly received memory address never reaches the address counter. An address that was fully received is kept, even when the following data word is cut short. A partial data word is dropped in every case.

Two strobes from the master-role side of the device are merged into the same log path: a missing acknowledge and an image checksum mismatch. When several faults arrive in one cycle, a fixed precedence selects the single record that is reported.

Top module: `i2c_slv_errclass`

## Requirements
- R1: The first byte after a START is taken as the device address. When bits 7:1 equal `DEV_ADDR` (default 7'h50) and the byte is acknowledged, bit 0 selects the transfer: 0 is a write (memory-address phase follows) and 1 is a read. Any other device address sends the block idle without an error record.
- R2: In a write, three acknowledged address bytes follow, most significant byte first. Their low 22 bits are loaded into `mem_addr` one cycle after the third byte.
- R3: Write data is packed four bytes at a time, first byte in bits 31:24. One cycle after the fourth byte, `wr_vld` pulses with `wr_addr` equal to the old `mem_addr` and the packed `wr_data`. In that same cycle `mem_addr` advances by one, wrapping from all ones to zero.
- R4: A START or STOP during the memory-address phase, before the third byte, logs code 0x12. It aborts the write, and `mem_addr` keeps its previous value.
- R5: A START or STOP that comes after a START but before the device address byte logs code 0x13 and aborts. The same holds for a START or STOP that comes after one to three bytes of a data word. In the data-word case, `mem_addr` keeps the loaded address and the partial word is discarded; no write occurs, and the next word is built only from new bytes.
- R6: A START or STOP on a word boundary of the write data phase is a normal end, with no record and no abort. This includes the case where no data bytes were sent at all. A START or STOP at any point of a read is also a normal end.
- R7: A NACK on a matched device address byte, on a memory-address byte or on a write data byte logs code 0x11 and aborts. A NACK on a read byte ends the read normally, with no record.
- R8: A `mst_nack` strobe logs code 0x11 and a `cksum_bad` strobe logs code 0x14. Neither one aborts the slave sequence.
- R9: An error record is `log_vld` high for one cycle, with `log_grp` = 4'h1 and `log_code`, in the cycle after the event. A record is produced only when `report_en` was high at the event. Aborts happen regardless of `report_en`.
- R10: When several faults coincide, exactly one record is emitted, chosen by this precedence: 0x12, then slave 0x13, then slave 0x11, then master 0x11, then 0x14.
- R11: After an abort the block is idle and ignores bytes until the next START. A START that causes an abort also opens a new device address phase.
- R12: `op_abort` pulses for one cycle, in the cycle after any slave abort (codes 0x12, 0x13 and slave 0x11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| report_en | input | 1 | Enables error records to the log |
| ev_start | input | 1 | START or repeated START seen (one-cycle strobe) |
| ev_stop | input | 1 | STOP seen (one-cycle strobe) |
| ev_byte | input | 1 | A byte and its acknowledge bit have been received |
| byte_in | input | 8 | Received byte, valid with `ev_byte` |
| ack_ok | input | 1 | 1 if the ninth bit was ACK, 0 if NACK |
| mst_nack | input | 1 | Master role: expected acknowledge missing |
| cksum_bad | input | 1 | Master role: image checksum mismatch |
| log_vld | output | 1 | Error record valid |
| log_grp | output | 4 | Error group |
| log_code | output | 8 | Error code |
| op_abort | output | 1 | Slave operation aborted |
| mem_addr | output | ADDR_W | Memory address counter (word address) |
| wr_vld | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 8*WORD_BYTES | Memory write data |

## Verification
A slave-side classification and a master-side strobe can land in the same cycle and compete for the single log port. The bench provokes this by raising a STOP in the middle of the address phase together with `cksum_bad`. It also raises a STOP after a partial data word together with `mst_nack`, and raises both master strobes at once. The scoreboard queues only the record that the precedence selects. A second record in that window shows up as an unexpected log entry, and a wrong winner shows up as a code miscompare.

// File: rtl/i2cec_pkg.sv
package i2cec_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_MADR,
      ST_WDATA,
      ST_RDATA
   } seq_st_e;

   typedef struct packed {
      logic [3:0] grp;
      logic [7:0] code;
   } log_rec_t;

   localparam logic [3:0] GRP_I2C  = 4'h1;
   localparam logic [7:0] C_NOACK  = 8'h11;
   localparam logic [7:0] C_ADRCUT = 8'h12;
   localparam logic [7:0] C_UNEXP  = 8'h13;
   localparam logic [7:0] C_CKSUM  = 8'h14;

endpackage

// File: rtl/i2cec_seq.sv
module i2cec_seq
   import i2cec_pkg::*;
#(
   parameter int          ADDR_BYTES = 3,
   parameter int          WORD_BYTES = 4,
   parameter logic [6:0]  DEV_ADDR   = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_byte,
   input  logic [7:0] byte_in,
   input  logic       ack_ok,
   output logic       err_adrcut,
   output logic       err_unexp,
   output logic       err_nack,
   output logic       adr_shift,
   output logic       adr_last,
   output logic       dat_shift,
   output logic       dat_last,
   output logic       abort
);

   localparam int MAXB  = (ADDR_BYTES > WORD_BYTES) ? ADDR_BYTES : WORD_BYTES;
   localparam int CNT_W = $clog2(MAXB) + 1;
   localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ADDR_BYTES - 1);
   localparam logic [CNT_W-1:0] W_LAST = CNT_W'(WORD_BYTES - 1);

   seq_st_e          st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             bus_edge, byte_ev, dev_hit;

   assign bus_edge = ev_start | ev_stop;
   assign byte_ev  = ev_byte & ~bus_edge;
   assign dev_hit  = (byte_in[7:1] == DEV_ADDR);

   // phase-based classification of bus events
   always_comb begin
      err_adrcut = bus_edge && (st == ST_MADR);
      err_unexp  = bus_edge && ((st == ST_DEV) || ((st == ST_WDATA) && (cnt != '0)));
      err_nack   = byte_ev && !ack_ok &&
                   (((st == ST_DEV) && dev_hit) || (st == ST_MADR) || (st == ST_WDATA));
      adr_shift  = byte_ev && ack_ok && (st == ST_MADR);
      adr_last   = adr_shift && (cnt == A_LAST);
      dat_shift  = byte_ev && ack_ok && (st == ST_WDATA);
      dat_last   = dat_shift && (cnt == W_LAST);
      abort      = err_adrcut | err_unexp | err_nack;
   end

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      if (ev_start) begin
         st_n  = ST_DEV;
         cnt_n = '0;
      end else if (ev_stop) begin
         st_n  = ST_IDLE;
         cnt_n = '0;
      end else if (ev_byte) begin
         case (st)
            ST_DEV: begin
               cnt_n = '0;
               if (dev_hit && ack_ok) st_n = byte_in[0] ? ST_RDATA : ST_MADR;
               else                   st_n = ST_IDLE;
            end
            ST_MADR: begin
               if (!ack_ok) begin
                  st_n  = ST_IDLE;
                  cnt_n = '0;
               end else if (cnt == A_LAST) begin
                  st_n  = ST_WDATA;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + CNT_W'(1);
               end
            end
            ST_WDATA: begin
               if (!ack_ok) begin
                  st_n  = ST_IDLE;
                  cnt_n = '0;
               end else if (cnt == W_LAST) begin
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + CNT_W'(1);
               end
            end
            ST_RDATA: begin
               if (!ack_ok) st_n = ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
      end
   end

endmodule

// File: rtl/i2cec_mem.sv
module i2cec_mem #(
   parameter int ADDR_W     = 22,
   parameter int ADDR_BYTES = 3,
   parameter int WORD_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [7:0]              byte_in,
   input  logic                    adr_shift,
   input  logic                    adr_last,
   input  logic                    dat_shift,
   input  logic                    dat_last,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic                    wr_vld,
   output logic [ADDR_W-1:0]       wr_addr,
   output logic [8*WORD_BYTES-1:0] wr_data
);

   localparam int AS_W = 8 * (ADDR_BYTES - 1);
   localparam int DS_W = 8 * (WORD_BYTES - 1);

   // partial bytes; after a full count every bit has been replaced
   logic [AS_W-1:0] adr_sh;
   logic [DS_W-1:0] dat_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_sh   <= '0;
         dat_sh   <= '0;
         mem_addr <= '0;
         wr_vld   <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_vld <= dat_last;
         if (adr_shift) adr_sh <= AS_W'({adr_sh, byte_in});
         if (dat_shift) dat_sh <= DS_W'({dat_sh, byte_in});
         if (adr_last) begin
            mem_addr <= ADDR_W'({adr_sh, byte_in});
         end else if (dat_last) begin
            wr_addr  <= mem_addr;
            wr_data  <= {dat_sh, byte_in};
            mem_addr <= mem_addr + ADDR_W'(1);
         end
      end
   end

endmodule

// File: rtl/i2cec_errsel.sv
module i2cec_errsel
   import i2cec_pkg::*;
#(
   parameter bit LOG_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       report_en,
   input  logic       err_adrcut,
   input  logic       err_unexp,
   input  logic       err_nack,
   input  logic       mst_nack,
   input  logic       cksum_bad,
   input  logic       abort,
   output logic       log_vld,
   output logic [3:0] log_grp,
   output logic [7:0] log_code,
   output logic       op_abort
);

   log_rec_t sel;
   logic     any_err;

   // fixed precedence: first match wins
   always_comb begin
      sel.grp = GRP_I2C;
      if (err_adrcut)     sel.code = C_ADRCUT;
      else if (err_unexp) sel.code = C_UNEXP;
      else if (err_nack)  sel.code = C_NOACK;
      else if (mst_nack)  sel.code = C_NOACK;
      else                sel.code = C_CKSUM;
      any_err = report_en & (err_adrcut | err_unexp | err_nack | mst_nack | cksum_bad);
   end

   generate
      if (LOG_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               log_vld  <= 1'b0;
               log_grp  <= '0;
               log_code <= '0;
               op_abort <= 1'b0;
            end else begin
               log_vld  <= any_err;
               op_abort <= abort;
               if (any_err) begin
                  log_grp  <= sel.grp;
                  log_code <= sel.code;
               end
            end
         end
      end else begin : g_comb
         assign log_vld  = any_err;
         assign log_grp  = any_err ? sel.grp  : '0;
         assign log_code = any_err ? sel.code : '0;
         assign op_abort = abort;
      end
   endgenerate

endmodule

// File: rtl/i2c_slv_errclass.sv
module i2c_slv_errclass #(
   parameter int         ADDR_W     = 22,
   parameter int         ADDR_BYTES = 3,
   parameter int         WORD_BYTES = 4,
   parameter logic [6:0] DEV_ADDR   = 7'h50,
   parameter bit         LOG_REG    = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    report_en,
   input  logic                    ev_start,
   input  logic                    ev_stop,
   input  logic                    ev_byte,
   input  logic [7:0]              byte_in,
   input  logic                    ack_ok,
   input  logic                    mst_nack,
   input  logic                    cksum_bad,
   output logic                    log_vld,
   output logic [3:0]              log_grp,
   output logic [7:0]              log_code,
   output logic                    op_abort,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic                    wr_vld,
   output logic [ADDR_W-1:0]       wr_addr,
   output logic [8*WORD_BYTES-1:0] wr_data
);

   generate
      if (ADDR_BYTES < 2) begin : g_bad_abytes
         $error("ADDR_BYTES must be at least 2");
      end
      if (ADDR_W > 8 * ADDR_BYTES || ADDR_W <= 8 * (ADDR_BYTES - 1)) begin : g_bad_aw
         $error("ADDR_W must need exactly ADDR_BYTES bytes");
      end
      if (WORD_BYTES < 2) begin : g_bad_wbytes
         $error("WORD_BYTES must be at least 2");
      end
   endgenerate

   logic err_adrcut, err_unexp, err_nack;
   logic adr_shift, adr_last, dat_shift, dat_last, abort;

   i2cec_seq #(
      .ADDR_BYTES (ADDR_BYTES),
      .WORD_BYTES (WORD_BYTES),
      .DEV_ADDR   (DEV_ADDR)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_start   (ev_start),
      .ev_stop    (ev_stop),
      .ev_byte    (ev_byte),
      .byte_in    (byte_in),
      .ack_ok     (ack_ok),
      .err_adrcut (err_adrcut),
      .err_unexp  (err_unexp),
      .err_nack   (err_nack),
      .adr_shift  (adr_shift),
      .adr_last   (adr_last),
      .dat_shift  (dat_shift),
      .dat_last   (dat_last),
      .abort      (abort)
   );

   i2cec_mem #(
      .ADDR_W     (ADDR_W),
      .ADDR_BYTES (ADDR_BYTES),
      .WORD_BYTES (WORD_BYTES)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_in   (byte_in),
      .adr_shift (adr_shift),
      .adr_last  (adr_last),
      .dat_shift (dat_shift),
      .dat_last  (dat_last),
      .mem_addr  (mem_addr),
      .wr_vld    (wr_vld),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data)
   );

   i2cec_errsel #(
      .LOG_REG (LOG_REG)
   ) u_errsel (
      .clk        (clk),
      .rst_n      (rst_n),
      .report_en  (report_en),
      .err_adrcut (err_adrcut),
      .err_unexp  (err_unexp),
      .err_nack   (err_nack),
      .mst_nack   (mst_nack),
      .cksum_bad  (cksum_bad),
      .abort      (abort),
      .log_vld    (log_vld),
      .log_grp    (log_grp),
      .log_code   (log_code),
      .op_abort   (op_abort)
   );

endmodule

// File: rtl/i2c_slv_errclass_chk.sv
module i2c_slv_errclass_chk #(
   parameter int ADDR_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              report_en,
   input logic              log_vld,
   input logic [3:0]        log_grp,
   input logic [7:0]        log_code,
   input logic              op_abort,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              wr_vld,
   input logic [ADDR_W-1:0] wr_addr
);

   a_r9_group: assert property (@(posedge clk) disable iff (!rst_n)
      log_vld |-> log_grp == 4'h1);

   a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
      log_vld |-> $past(report_en));

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld |-> mem_addr == wr_addr + ADDR_W'(1));

   a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (log_vld && log_code == 8'h12) |-> mem_addr == $past(mem_addr));

   a_r12_slave_err_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (log_vld && (log_code == 8'h12 || log_code == 8'h13)) |-> op_abort);

   a_r5_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      op_abort |-> !wr_vld);

endmodule

bind i2c_slv_errclass i2c_slv_errclass_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .report_en (report_en),
   .log_vld   (log_vld),
   .log_grp   (log_grp),
   .log_code  (log_code),
   .op_abort  (op_abort),
   .mem_addr  (mem_addr),
   .wr_vld    (wr_vld),
   .wr_addr   (wr_addr)
);

// File: tb/i2c_slv_errclass_bench.sv
module i2c_slv_errclass_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        report_en = 1'b1;
   logic        ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
   logic [7:0]  byte_in = 8'h00;
   logic        ack_ok = 1'b0, mst_nack = 1'b0, cksum_bad = 1'b0;
   logic        log_vld, op_abort, wr_vld;
   logic [3:0]  log_grp;
   logic [7:0]  log_code;
   logic [21:0] mem_addr, wr_addr;
   logic [31:0] wr_data;

   int n_chk = 0;
   int n_bad = 0;

   logic [11:0] exp_log[$];
   logic [53:0] exp_wr[$];

   always #4 clk = ~clk;

   i2c_slv_errclass u_i2c_slv_errclass (
      .clk(clk), .rst_n(rst_n), .report_en(report_en),
      .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte),
      .byte_in(byte_in), .ack_ok(ack_ok), .mst_nack(mst_nack), .cksum_bad(cksum_bad),
      .log_vld(log_vld), .log_grp(log_grp), .log_code(log_code), .op_abort(op_abort),
      .mem_addr(mem_addr), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   // scoreboard monitor: R9 records and R3 writes
   always @(negedge clk) begin
      if (rst_n) begin
         if (log_vld) begin
            if (exp_log.size() == 0) check("R9 unexpected record", {52'd0, log_grp, log_code}, 64'hFFF);
            else check("R9/R10 log record", {52'd0, log_grp, log_code}, {52'd0, exp_log.pop_front()});
         end
         if (wr_vld) begin
            if (exp_wr.size() == 0) check("R3 unexpected write", {10'd0, wr_addr, wr_data}, 64'hFFFF);
            else check("R3 write record", {10'd0, wr_addr, wr_data}, {10'd0, exp_wr.pop_front()});
         end
      end
   end

   task automatic step(input logic s, input logic p, input logic b, input logic [7:0] d,
                       input logic a, input logic mn, input logic ck);
      @(negedge clk);
      ev_start = s; ev_stop = p; ev_byte = b; byte_in = d; ack_ok = a;
      mst_nack = mn; cksum_bad = ck;
      @(negedge clk);
      ev_start = 0; ev_stop = 0; ev_byte = 0; ack_ok = 0; mst_nack = 0; cksum_bad = 0;
   endtask

   task automatic bstart(); step(1, 0, 0, 8'h00, 0, 0, 0); endtask
   task automatic bstop();  step(0, 1, 0, 8'h00, 0, 0, 0); endtask
   task automatic bbyte(input logic [7:0] d, input logic a); step(0, 0, 1, d, a, 0, 0); endtask
   task automatic waddr(input logic [7:0] a2, input logic [7:0] a1, input logic [7:0] a0);
      bstart(); bbyte(8'hA0, 1); bbyte(a2, 1); bbyte(a1, 1); bbyte(a0, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset log_vld", log_vld, 0);
      check("R3 reset wr_vld", wr_vld, 0);
      check("R2 reset mem_addr", mem_addr, 0);
      check("R12 reset op_abort", op_abort, 0);
      rst_n = 1'b1;

      // R1 R2 R3: full write; then R5 partial word cut by STOP
      waddr(8'h12, 8'h34, 8'h56);
      check("R2 address loaded", mem_addr, 22'h123456);
      exp_wr.push_back({22'h123456, 32'hDEADBEEF});
      bbyte(8'hDE, 1); bbyte(8'hAD, 1); bbyte(8'hBE, 1); bbyte(8'hEF, 1);
      check("R3 counter advanced", mem_addr, 22'h123457);
      bbyte(8'h11, 1); bbyte(8'h22, 1);
      exp_log.push_back(12'h113);
      bstop();
      check("R5 abort on partial word", op_abort, 1);
      check("R5 counter kept", mem_addr, 22'h123457);
      // R5 partial bytes discarded: next word built only from new bytes
      waddr(8'h00, 8'h00, 8'h21);
      exp_wr.push_back({22'h000021, 32'h01020304});
      bbyte(8'h01, 1); bbyte(8'h02, 1); bbyte(8'h03, 1); bbyte(8'h04, 1);
      bstop();
      check("R6 stop on word boundary", op_abort, 0);

      // R4: STOP in address phase
      bstart(); bbyte(8'hA0, 1); bbyte(8'hFF, 1); bbyte(8'h00, 1);
      exp_log.push_back(12'h112);
      bstop();
      check("R4 address unchanged", mem_addr, 22'h000022);
      check("R4 abort", op_abort, 1);
      // R4 + R11: START in address phase opens new address phase
      bstart(); bbyte(8'hA0, 1); bbyte(8'h77, 1);
      exp_log.push_back(12'h112);
      bstart();
      bbyte(8'hA0, 1); bbyte(8'h01, 1); bbyte(8'h02, 1); bbyte(8'h03, 1);
      check("R11 restart after START abort", mem_addr, 22'h010203);

      // R5: START before device address byte, then R11 new phase
      bstart();
      exp_log.push_back(12'h113);
      bstart();
      check("R5 abort in device phase", op_abort, 1);
      bbyte(8'hA0, 1); bbyte(8'h00, 1); bbyte(8'h00, 1); bbyte(8'h10, 1);
      check("R11 new phase after START", mem_addr, 22'h000010);
      bstop();
      check("R6 address-only write ends normally", op_abort, 0);

      // R7: NACK on address byte, then R11 bytes ignored
      bstart(); bbyte(8'hA0, 1);
      exp_log.push_back(12'h111);
      bbyte(8'h05, 0);
      check("R7 abort on NACK", op_abort, 1);
      bbyte(8'h00, 1); bbyte(8'h00, 1); bbyte(8'h00, 1); bbyte(8'h00, 1);
      check("R11 bytes ignored while idle", mem_addr, 22'h000010);
      check("R11 no write while idle", wr_vld, 0);
      bstop();
      // R7: NACK on matched device address
      bstart();
      exp_log.push_back(12'h111);
      bbyte(8'hA0, 0);
      bstop();

      // R7 R6: read ended by NACK, and read cut by STOP
      bstart(); bbyte(8'hA1, 1); bbyte(8'h00, 1); bbyte(8'h00, 0);
      check("R7 read NACK is normal", op_abort, 0);
      bstop();
      bstart(); bbyte(8'hA1, 1); bbyte(8'h33, 1); bstop();
      check("R6 STOP during read normal", op_abort, 0);

      // R1: other device address ignored
      bstart(); bbyte(8'h84, 1); bbyte(8'h00, 0); bbyte(8'h01, 1); bstop();
      check("R1 foreign address no abort", op_abort, 0);
      check("R1 foreign address no change", mem_addr, 22'h000010);

      // R8: master-role strobes
      exp_log.push_back(12'h111);
      step(0, 0, 0, 8'h00, 0, 1, 0);
      check("R8 master NACK no abort", op_abort, 0);
      exp_log.push_back(12'h114);
      step(0, 0, 0, 8'h00, 0, 0, 1);

      // R10: coinciding faults give one record
      bstart(); bbyte(8'hA0, 1); bbyte(8'hAA, 1);
      exp_log.push_back(12'h112);
      step(0, 1, 0, 8'h00, 0, 0, 1);
      exp_log.push_back(12'h111);
      step(0, 0, 0, 8'h00, 0, 1, 1);
      waddr(8'h00, 8'h00, 8'h30); bbyte(8'h99, 1);
      exp_log.push_back(12'h113);
      step(0, 1, 0, 8'h00, 0, 1, 0);
      check("R10 address kept", mem_addr, 22'h000030);

      // R9: reporting disabled
      @(negedge clk); report_en = 1'b0;
      waddr(8'h00, 8'h00, 8'h40); bbyte(8'h01, 1); bstop();
      check("R9 abort without record", op_abort, 1);
      step(0, 0, 0, 8'h00, 0, 0, 1);
      check("R9 no record when disabled", log_vld, 0);
      @(negedge clk); report_en = 1'b1;

      // R2 truncation and R3 wrap
      waddr(8'hFF, 8'hFF, 8'hFF);
      check("R2 truncated to 22 bits", mem_addr, 22'h3FFFFF);
      exp_wr.push_back({22'h3FFFFF, 32'hCAFEBABE});
      bbyte(8'hCA, 1); bbyte(8'hFE, 1); bbyte(8'hBA, 1); bbyte(8'hBE, 1);
      check("R3 wrap to zero", mem_addr, 22'h000000);
      exp_wr.push_back({22'h000000, 32'h00000001});
      bbyte(8'h00, 1); bbyte(8'h00, 1); bbyte(8'h00, 1); bbyte(8'h01, 1);
      bstart();
      check("R6 repeated START on boundary", op_abort, 0);
      bbyte(8'hA1, 1); bstop();
      check("R3 counter after two words", mem_addr, 22'h000001);

      repeat (4) @(negedge clk);
      check("R9 all records seen", exp_log.size(), 0);
      check("R3 all writes seen", exp_wr.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule